// File: doc/BRIEF.md
# Slave-Select / General-Purpose Pin Port Controller

This block drives four pad pins that are shared between two roles. A pin in its slave-select role passes through the active-low select that the SPI engine produces. A pin in its general-purpose role is driven from a port latch, and one of four drive types shapes that drive. Commands from the bridge's command decoder do four things: load the port latch, load the role mask, load the drive-type register, or capture the filtered pin levels into a byte that goes back to the data buffer.

The pad is controlled through four digital enables per pin: a strong pull-down, a strong pull-up, a weak pull-up and a very-weak pull-up. In quasi-bidirectional mode the pull-ups behave as follows. The very-weak pull-up follows the latch. The weak pull-up also needs the pin itself to read high. A rise of the latch adds a strong pull-up for a fixed two clocks. Every pin input passes through a per-pin deglitch counter of `FILT_CYCLES` clocks before anything uses it.

Top module: `gpio_sel_port`

## Requirements
- R1: After reset every pin is in the slave-select role. In that role the pin drives `pull_dn_o` = NOT `ss_n_i` and `strong_up_o` = `ss_n_i`, with both weak pull-ups off. The latch and drive-type register reset to zero, and the filtered levels reset to 1.
- R2: A role-mask command (`cmd_op` = 2'b01) with bit n of `cmd_data` set to 1 places pin n in the general-purpose role. The same bit at 0 returns pin n to the slave-select role.
- R3: A pin that changes from slave-select to general-purpose starts in quasi-bidirectional mode, whatever its drive-type bits held before.
- R4: A drive-type command (`cmd_op` = 2'b10) loads bits 2n+1:2n of `cmd_data` as pin n's type: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain.
- R5: In quasi-bidirectional mode the very-weak pull-up is on exactly when the latch bit is 1. The weak pull-up is on only when the latch bit is 1 and the filtered pin level is 1.
- R6: In quasi-bidirectional mode, a latch bit that goes from 0 to 1 turns the strong pull-up on for exactly two clocks.
- R7: When the latch is 0, the pull-down is on in push-pull, open-drain and quasi-bidirectional modes. Push-pull turns the strong pull-up on when the latch is 1. Open-drain never turns on a pull-up. Input-only keeps all four enables off.
- R8: A latch command (`cmd_op` = 2'b00) loads bit n of `cmd_data` into latch bit n only for pins in the general-purpose role. The latch bits of slave-select pins keep their value.
- R9: A capture command (`cmd_op` = 2'b11) loads `rd_byte_o` with the filtered pin levels in bits 3:0, ANDed with the role mask, and zeros above. `rd_valid_o` is high for the one clock that follows.
- R10: A pin level reaches the filtered value only after it has differed from that value on `FILT_CYCLES` consecutive clock edges. A shorter excursion is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one clock per command |
| cmd_op | input | 2 | 00 latch, 01 role mask, 10 drive type, 11 capture |
| cmd_data | input | 8 | Command data byte |
| ss_n_i | input | 4 | Active-low selects from the SPI engine |
| pin_i | input | 4 | Raw pad input levels |
| pull_dn_o | output | 4 | Strong pull-down enable per pin |
| strong_up_o | output | 4 | Strong pull-up enable per pin |
| weak_up_o | output | 4 | Weak pull-up enable per pin |
| vweak_up_o | output | 4 | Very-weak pull-up enable per pin |
| rd_byte_o | output | 8 | Captured pin byte for the data buffer |
| rd_valid_o | output | 1 | Capture byte valid, one clock |

## Verification
A command takes effect at the clock edge that samples it. The pad enables are combinational from registers, so they settle by the next falling edge. The bench drives commands on a falling edge and checks on the falling edge that follows. The two-clock strong pull-up is checked on three falling edges in a row after a latch rise: on, on, then off. A pin change reaches the weak pull-up and the capture byte only after `FILT_CYCLES` rising edges. The bench runs with a filter of four, holds a pin for three edges to show the rejection, and holds it for four to show the acceptance. `rd_valid_o` and `rd_byte_o` are checked one falling edge after the capture command.

// File: rtl/gpio_sel_port.sv
module gpio_sel_port #(
  parameter int NPINS       = 4,
  parameter int FILT_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic [NPINS-1:0] ss_n_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pull_dn_o,
  output logic [NPINS-1:0] strong_up_o,
  output logic [NPINS-1:0] weak_up_o,
  output logic [NPINS-1:0] vweak_up_o,
  output logic [7:0]       rd_byte_o,
  output logic             rd_valid_o
);

  localparam int FCW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [FCW-1:0] FLIM = FCW'(FILT_CYCLES - 1);

  localparam logic [1:0] OP_LATCH = 2'b00;
  localparam logic [1:0] OP_ROLE  = 2'b01;
  localparam logic [1:0] OP_TYPE  = 2'b10;
  localparam logic [1:0] OP_CAP   = 2'b11;

  localparam logic [1:0] M_QUASI = 2'b00;
  localparam logic [1:0] M_PP    = 2'b01;
  localparam logic [1:0] M_IN    = 2'b10;
  localparam logic [1:0] M_OD    = 2'b11;

  logic [NPINS-1:0]   en_q, latch_q, latch_nx, filt;
  logic [2*NPINS-1:0] cfg_q;
  logic [NPINS-1:0]   rise;

  wire wr_latch = cmd_valid && (cmd_op == OP_LATCH);
  wire wr_role  = cmd_valid && (cmd_op == OP_ROLE);
  wire wr_type  = cmd_valid && (cmd_op == OP_TYPE);
  wire do_cap   = cmd_valid && (cmd_op == OP_CAP);

  assign latch_nx = wr_latch ? ((cmd_data[NPINS-1:0] & en_q) | (latch_q & ~en_q)) : latch_q;
  assign rise     = latch_nx & ~latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      latch_q    <= '0;
      cfg_q      <= '0;
      rd_byte_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      latch_q    <= latch_nx;
      rd_valid_o <= do_cap;
      if (do_cap) rd_byte_o <= 8'(filt & en_q);
      if (wr_type) cfg_q <= cmd_data[2*NPINS-1:0];
      if (wr_role) begin
        en_q <= cmd_data[NPINS-1:0];
        for (int p = 0; p < NPINS; p++)
          if (cmd_data[p] && !en_q[p]) cfg_q[2*p +: 2] <= M_QUASI;
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [FCW-1:0] fcnt;
    logic           flvl;
    logic [1:0]     kick;
    logic           pd, su, wu, vw;
    wire  [1:0]     mode = cfg_q[2*p +: 2];
    wire            lat  = latch_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fcnt <= '0;
        flvl <= 1'b1;
      end else if (pin_i[p] == flvl) begin
        fcnt <= '0;
      end else if (fcnt == FLIM) begin
        flvl <= pin_i[p];
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
    assign filt[p] = flvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           kick <= 2'd0;
      else if (rise[p])     kick <= 2'd2;
      else if (kick != 0)   kick <= kick - 2'd1;
    end

    always_comb begin
      pd = 1'b0;
      su = 1'b0;
      wu = 1'b0;
      vw = 1'b0;
      if (!en_q[p]) begin
        pd = ~ss_n_i[p];
        su = ss_n_i[p];
      end else begin
        case (mode)
          M_QUASI: begin
            pd = ~lat;
            su = lat && (kick != 2'd0);
            wu = lat && flvl;
            vw = lat;
          end
          M_PP: begin
            pd = ~lat;
            su = lat;
          end
          M_OD:    pd = ~lat;
          default: ;
        endcase
      end
    end

    assign pull_dn_o[p]   = pd;
    assign strong_up_o[p] = su;
    assign weak_up_o[p]   = wu;
    assign vweak_up_o[p]  = vw;
  end

endmodule

// File: rtl/gpio_sel_port_chk.sv
module gpio_sel_port_chk #(
  parameter int NPINS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [7:0]         cmd_data,
  input logic [NPINS-1:0]   ss_n_i,
  input logic [NPINS-1:0]   pull_dn_o,
  input logic [NPINS-1:0]   strong_up_o,
  input logic [NPINS-1:0]   weak_up_o,
  input logic [NPINS-1:0]   vweak_up_o,
  input logic               rd_valid_o,
  input logic [NPINS-1:0]   en_q,
  input logic [NPINS-1:0]   latch_q,
  input logic [2*NPINS-1:0] cfg_q
);

  AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> rd_valid_o); // R9

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    AST_SELECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[p] |-> (pull_dn_o[p] == !ss_n_i[p]) && (strong_up_o[p] == ss_n_i[p])
                   && !weak_up_o[p] && !vweak_up_o[p]); // R1

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_dn_o[p] && (strong_up_o[p] || weak_up_o[p] || vweak_up_o[p]))); // R7

    AST_INPUT_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && cfg_q[2*p +: 2] == 2'b10) |->
        !(pull_dn_o[p] || strong_up_o[p] || weak_up_o[p] || vweak_up_o[p])); // R7

    AST_VWEAK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && cfg_q[2*p +: 2] == 2'b00) |-> (vweak_up_o[p] == latch_q[p])); // R5

    AST_KICK_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && cfg_q[2*p +: 2] == 2'b00 && $past(en_q[p]) && $past(cfg_q[2*p +: 2]) == 2'b00
       && $past(en_q[p], 2) && $past(cfg_q[2*p +: 2], 2) == 2'b00
       && strong_up_o[p] && $past(strong_up_o[p])) |-> !$past(strong_up_o[p], 2)); // R6

    AST_LATCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b00 && !en_q[p]) |=> $stable(latch_q[p])); // R8

    AST_NEW_PIN_QUASI: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && cmd_data[p] && !en_q[p]) |=> cfg_q[2*p +: 2] == 2'b00); // R3
  end

endmodule

bind gpio_sel_port gpio_sel_port_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/test_gpio_sel_port.sv
module test_gpio_sel_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [3:0] ss_n_i = 4'hF;
  logic [3:0] pin_i = 4'hF;
  logic [3:0] pull_dn_o, strong_up_o, weak_up_o, vweak_up_o;
  logic [7:0] rd_byte_o;
  logic       rd_valid_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_sel_port #(.NPINS(4), .FILT_CYCLES(4)) i_gpio_sel_port (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(8'(pull_dn_o), 8'h00, "R1 reset pull_dn");
    check(8'(strong_up_o), 8'h0F, "R1 reset strong_up");
    check(8'(weak_up_o | vweak_up_o), 8'h00, "R1 reset weak pulls");
    check(8'(rd_valid_o), 8'h00, "R1 reset rd_valid");
  endtask

  task automatic t_select_role;
    @(negedge clk); ss_n_i = 4'b1010;
    #1;
    check(8'(pull_dn_o), 8'h05, "R1 select pull_dn");
    check(8'(strong_up_o), 8'h0A, "R1 select strong_up");
    @(negedge clk); ss_n_i = 4'hF;
  endtask

  task automatic t_latch_mask;
    cmd(2'b00, 8'h0F);
    cmd(2'b01, 8'h01);
    check(8'(pull_dn_o), 8'h01, "R8 latch of select pin untouched");
    check(8'(strong_up_o), 8'h0E, "R2 pin0 left select role");
  endtask

  task automatic t_quasi;
    cmd(2'b10, 8'hFF);
    cmd(2'b01, 8'h0F);
    check(8'(pull_dn_o), 8'h0F, "R3 new pins quasi, pin0 open-drain, latch 0");
    check(8'(vweak_up_o), 8'h00, "R5 vweak off with latch 0");
    cmd(2'b00, 8'h0F);
    check(8'(strong_up_o), 8'h0E, "R6 kick first clock");
    check(8'(pull_dn_o), 8'h00, "R7 pull_dn off with latch 1");
    check(8'(vweak_up_o), 8'h0E, "R5 vweak on latch 1");
    check(8'(weak_up_o), 8'h0E, "R5 weak on latch 1 pin 1");
    @(negedge clk);
    check(8'(strong_up_o), 8'h0E, "R6 kick second clock");
    @(negedge clk);
    check(8'(strong_up_o), 8'h00, "R6 kick ended");
    pin_i[1] = 1'b0;
    repeat (4) @(negedge clk);
    check(8'(weak_up_o), 8'h0C, "R5 weak off when pin reads 0");
    check(8'(vweak_up_o), 8'h0E, "R5 vweak stays with pin 0");
    pin_i[1] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_modes;
    cmd(2'b10, 8'h2D);
    check(8'(strong_up_o), 8'h01, "R4 R7 push-pull strong high");
    check(8'(pull_dn_o), 8'h00, "R7 no pull_dn latch 1");
    check(8'(vweak_up_o), 8'h08, "R4 only quasi pin3 vweak");
    check(8'(weak_up_o), 8'h08, "R4 only quasi pin3 weak");
    cmd(2'b00, 8'h00);
    check(8'(pull_dn_o), 8'h0B, "R7 pull_dn except input-only");
    check(8'(strong_up_o), 8'h00, "R7 no strong latch 0");
    cmd(2'b01, 8'h0A);
    check(8'(pull_dn_o), 8'h0A, "R2 pins0,2 back to select pull_dn");
    check(8'(strong_up_o), 8'h05, "R2 pins0,2 back to select strong");
  endtask

  task automatic t_capture;
    pin_i = 4'b0110;
    repeat (5) @(negedge clk);
    cmd(2'b11, 8'h00);
    check(8'(rd_valid_o), 8'h01, "R9 rd_valid pulse");
    check(rd_byte_o, 8'h02, "R9 byte masked by role");
    @(negedge clk);
    check(8'(rd_valid_o), 8'h00, "R9 rd_valid single clock");
    check(rd_byte_o, 8'h02, "R9 byte held");
  endtask

  task automatic t_filter;
    cmd(2'b01, 8'h0F);
    pin_i[0] = 1'b1;
    repeat (3) @(negedge clk);
    pin_i[0] = 1'b0;
    repeat (2) @(negedge clk);
    cmd(2'b11, 8'h00);
    check(rd_byte_o, 8'h06, "R10 three-clock glitch rejected");
    pin_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    cmd(2'b11, 8'h00);
    check(rd_byte_o, 8'h07, "R10 four-clock level accepted");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select_role();
    t_latch_mask();
    t_quasi();
    t_modes();
    t_capture();
    t_filter();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule